// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Pointer

This block holds the stack pointer of a small 8-bit controller core and carries out single-byte stack pushes and pops against a 256-byte internal data RAM. The RAM is kept inside the block as a plain behavioural array. The stack grows toward higher addresses. A push moves the pointer up by one and then stores the byte at the new pointer. A pop returns the byte at the current pointer and then moves the pointer down by one.

The pointer leaves reset at 0x07, so the first pushed byte lands at 0x08. That address is the first register of the second register bank. The pointer is also a special function register that software can reload at any time. Software has to reload it before more than one register bank is used, so that the stack does not overwrite working registers. A reload issued in the same cycle as a stack operation wins, and the stack operation is dropped. The pointer wraps modulo 256 in both directions and no fault is raised.

Top module: `upstk_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sp_o` reads 0x07 and `pop_vld_o` is 0.
- R2: A push presents `ram_addr_o` = `sp_o`+1 with `ram_we_o` high in the same cycle. From the next cycle the pointer equals the old pointer plus one. The first push after reset therefore writes address 0x08.
- R3: A pop presents `ram_addr_o` = `sp_o` with `ram_re_o` high. In the next cycle `pop_vld_o` is high for one cycle and `pop_data_o` holds the byte stored at that address. The pointer then equals the old pointer minus one.
- R4: Bytes that are pushed are returned by pops in reverse order (last in, first out).
- R5: A software write (`sp_we_i` high) sets `sp_o` to `sp_wdata_i` from the next cycle on. Pushes and pops that follow use the new pointer.
- R6: A software write in the same cycle as a push or a pop takes priority. The RAM is not written, `ram_we_o` and `ram_re_o` stay low, no `pop_vld_o` pulse follows, and the pointer takes the written value.
- R7: A push at pointer 0xFF writes address 0x00 and leaves the pointer at 0x00. A pop at pointer 0x00 leaves the pointer at 0xFF. No fault indication exists.
- R8: In a cycle with no push, no pop and no software write, the pointer holds its value and both RAM strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop request for this cycle |
| sp_we_i | input | 1 | Software write of the pointer register |
| sp_wdata_i | input | 8 | Value for the software write |
| sp_o | output | 8 | Current pointer value (register read) |
| pop_data_o | output | 8 | Popped byte, registered |
| pop_vld_o | output | 1 | Pulses high the cycle after a pop |
| ram_addr_o | output | 8 | RAM address in use this cycle |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |

## Verification
The assertions take for granted that a push and a pop are never requested in the same cycle. The core issues only one stack operation per cycle, and the checker treats a simultaneous request as a violation of that input rule. The bench drives every stack operation through tasks that raise only one of the two requests at a time. It does combine a request with a software pointer write, because that priority case is legal. The bench only pops addresses it has written earlier, so every expected byte is defined.

// File: rtl/upstk_pkg.sv
package upstk_pkg;
   typedef enum logic [1:0] {
      SOP_IDLE = 2'd0,
      SOP_PUSH = 2'd1,
      SOP_POP  = 2'd2,
      SOP_LOAD = 2'd3
   } stk_op_e;
endpackage

// File: rtl/upstk_arb.sv
module upstk_arb
   import upstk_pkg::*;
(
   input  logic    push_i,
   input  logic    pop_i,
   input  logic    sp_we_i,
   output stk_op_e op_o
);
   // software load first, then push, then pop
   always_comb begin
      if (sp_we_i)      op_o = SOP_LOAD;
      else if (push_i)  op_o = SOP_PUSH;
      else if (pop_i)   op_o = SOP_POP;
      else              op_o = SOP_IDLE;
   end
endmodule

// File: rtl/upstk_ptr.sv
module upstk_ptr
   import upstk_pkg::*;
#(
   parameter int unsigned PTR_W     = 8,
   parameter int unsigned RESET_PTR = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op_i,
   input  logic [PTR_W-1:0] load_val_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [PTR_W-1:0] addr_o
);
   localparam logic [PTR_W-1:0] PTR_RST = PTR_W'(RESET_PTR);
   localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_inc;
   logic [PTR_W-1:0] ptr_dec;
   logic [PTR_W-1:0] ptr_d;

   // modulo 2**PTR_W arithmetic, wrap is silent
   assign ptr_inc = ptr_q + ONE;
   assign ptr_dec = ptr_q - ONE;

   always_comb begin
      unique case (op_i)
         SOP_PUSH: ptr_d = ptr_inc;
         SOP_POP:  ptr_d = ptr_dec;
         SOP_LOAD: ptr_d = load_val_i;
         default:  ptr_d = ptr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= PTR_RST;
      else        ptr_q <= ptr_d;
   end

   // pre-increment addressing for push, current slot otherwise
   assign addr_o = (op_i == SOP_PUSH) ? ptr_inc : ptr_q;
   assign ptr_o  = ptr_q;
endmodule

// File: rtl/upstk_ram.sv
module upstk_ram #(
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 8,
   parameter bit          RD_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          we_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          re_i,
   output logic [DW-1:0] rdata_o,
   output logic          rvld_o
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_q;
   logic          vld_q;

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= re_i;
   end

   generate
      if (RD_HOLD) begin : g_rd_hold
         // output keeps the last popped byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rd_q <= '0;
            else if (re_i) rd_q <= mem[addr_i];
         end
      end else begin : g_rd_clear
         // output is zero whenever no pop completed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= re_i ? mem[addr_i] : '0;
         end
      end
   endgenerate

   assign rdata_o = rd_q;
   assign rvld_o  = vld_q;
endmodule

// File: rtl/upstk_top.sv
module upstk_top
   import upstk_pkg::*;
#(
   parameter int unsigned PTR_W     = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RESET_PTR = 7,
   parameter bit          RD_HOLD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   input  logic              sp_we_i,
   input  logic [PTR_W-1:0]  sp_wdata_i,
   output logic [PTR_W-1:0]  sp_o,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              pop_vld_o,
   output logic [PTR_W-1:0]  ram_addr_o,
   output logic              ram_we_o,
   output logic              ram_re_o
);
   generate
      if (PTR_W < 2 || PTR_W > 12) begin : g_bad_ptr_w
         $error("upstk_top: PTR_W must lie in 2..12");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("upstk_top: DATA_W must be at least 1");
      end
      if (RESET_PTR >= (1 << PTR_W)) begin : g_bad_reset
         $error("upstk_top: RESET_PTR out of pointer range");
      end
   endgenerate

   stk_op_e          op;
   logic [PTR_W-1:0] addr;

   upstk_arb u_arb (
      .push_i  (push_i),
      .pop_i   (pop_i),
      .sp_we_i (sp_we_i),
      .op_o    (op)
   );

   upstk_ptr #(
      .PTR_W     (PTR_W),
      .RESET_PTR (RESET_PTR)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .load_val_i (sp_wdata_i),
      .ptr_o      (sp_o),
      .addr_o     (addr)
   );

   logic we, re;
   assign we = (op == SOP_PUSH);
   assign re = (op == SOP_POP);

   upstk_ram #(
      .AW      (PTR_W),
      .DW      (DATA_W),
      .RD_HOLD (RD_HOLD)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr),
      .we_i    (we),
      .wdata_i (push_data_i),
      .re_i    (re),
      .rdata_o (pop_data_o),
      .rvld_o  (pop_vld_o)
   );

   assign ram_addr_o = addr;
   assign ram_we_o   = we;
   assign ram_re_o   = re;
endmodule

// File: rtl/upstk_chk.sv
module upstk_chk #(
   parameter int unsigned PTR_W     = 8,
   parameter int unsigned RESET_PTR = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_i,
   input logic             pop_i,
   input logic             sp_we_i,
   input logic [PTR_W-1:0] sp_wdata_i,
   input logic [PTR_W-1:0] sp_o,
   input logic             pop_vld_o,
   input logic [PTR_W-1:0] ram_addr_o,
   input logic             ram_we_o,
   input logic             ram_re_o
);
   logic out_of_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_of_rst <= 1'b0;
      else        out_of_rst <= 1'b1;
   end

   a_in_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));

   a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
      !out_of_rst |-> (sp_o == PTR_W'(RESET_PTR) && !pop_vld_o));

   a_r2_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !sp_we_i) |-> (ram_we_o && ram_addr_o == PTR_W'(sp_o + 1'b1)));

   a_r2_push_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !sp_we_i) |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)));

   a_r3_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !sp_we_i) |-> (ram_re_o && ram_addr_o == sp_o));

   a_r3_pop_decr: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !sp_we_i) |=> (pop_vld_o && sp_o == PTR_W'($past(sp_o) - 1'b1)));

   a_r5_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we_i |=> (sp_o == $past(sp_wdata_i)));

   a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we_i |-> (!ram_we_o && !ram_re_o));

   a_r6_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we_i |=> !pop_vld_o);

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i && !sp_we_i) |-> (!ram_we_o && !ram_re_o));

   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i && !sp_we_i) |=> $stable(sp_o));
endmodule

bind upstk_top upstk_chk #(
   .PTR_W     (PTR_W),
   .RESET_PTR (RESET_PTR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_i     (push_i),
   .pop_i      (pop_i),
   .sp_we_i    (sp_we_i),
   .sp_wdata_i (sp_wdata_i),
   .sp_o       (sp_o),
   .pop_vld_o  (pop_vld_o),
   .ram_addr_o (ram_addr_o),
   .ram_we_o   (ram_we_o),
   .ram_re_o   (ram_re_o)
);

// File: tb/upstk_top_tb_top.sv
`timescale 1ns/1ps
module upstk_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0;
   logic [7:0] push_data_i = '0;
   logic       pop_i = 1'b0;
   logic       sp_we_i = 1'b0;
   logic [7:0] sp_wdata_i = '0;
   logic [7:0] sp_o, pop_data_o, ram_addr_o;
   logic       pop_vld_o, ram_we_o, ram_re_o;

   always #5 clk = ~clk;

   upstk_top dut_i (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
      .pop_i(pop_i), .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
      .sp_o(sp_o), .pop_data_o(pop_data_o), .pop_vld_o(pop_vld_o),
      .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o)
   );

   int unsigned n_run = 0;
   int unsigned n_fail = 0;
   logic [7:0]  m_mem [256];
   logic [7:0]  m_sp = 8'h07;
   logic [7:0]  exp_q [$];
   bit          done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: compares each popped byte against the scoreboard queue (R3, R4)
   always @(negedge clk) begin
      if (rst_n && pop_vld_o) begin
         if (exp_q.size() == 0) chk(1'b0, "R6 unexpected pop valid", 1, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(pop_data_o == e, "R4 pop data", pop_data_o, e);
         end
      end
   end

   task automatic do_push(input logic [7:0] d);
      @(negedge clk);
      push_i = 1'b1; push_data_i = d;
      #1;
      chk(ram_we_o && ram_addr_o == 8'(m_sp + 1), "R2 push address", ram_addr_o, 8'(m_sp + 1));
      @(posedge clk); #1;
      push_i = 1'b0;
      m_sp = m_sp + 1; m_mem[m_sp] = d;
      chk(sp_o == m_sp, "R2 pointer after push", sp_o, m_sp);
   endtask

   task automatic do_pop();
      @(negedge clk);
      pop_i = 1'b1;
      #1;
      chk(ram_re_o && ram_addr_o == m_sp, "R3 pop address", ram_addr_o, m_sp);
      exp_q.push_back(m_mem[m_sp]);
      @(posedge clk); #1;
      pop_i = 1'b0;
      m_sp = m_sp - 1;
      chk(sp_o == m_sp, "R3 pointer after pop", sp_o, m_sp);
   endtask

   // sw load, optionally together with a push (op=1) or pop (op=2)
   task automatic do_load(input logic [7:0] v, input int op);
      @(negedge clk);
      sp_we_i = 1'b1; sp_wdata_i = v;
      push_i = (op == 1); pop_i = (op == 2); push_data_i = 8'hEE;
      #1;
      if (op != 0) chk(!ram_we_o && !ram_re_o, "R6 strobes suppressed", {ram_we_o, ram_re_o}, 0);
      @(posedge clk); #1;
      sp_we_i = 1'b0; push_i = 1'b0; pop_i = 1'b0;
      m_sp = v;
      chk(sp_o == v, "R5 pointer loaded", sp_o, v);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] lfsr;
      repeat (3) @(posedge clk);
      #1;
      chk(sp_o == 8'h07, "R1 reset pointer", sp_o, 8'h07);
      chk(!pop_vld_o && !ram_we_o, "R1 reset strobes", {pop_vld_o, ram_we_o}, 0);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk(sp_o == 8'h07, "R1 pointer after release", sp_o, 8'h07);

      // R2: first push lands at 0x08
      do_push(8'h3C);
      do_pop();
      // R8: idle cycles leave everything alone
      repeat (3) begin
         @(negedge clk); #1;
         chk(!ram_we_o && !ram_re_o && sp_o == m_sp, "R8 idle", sp_o, m_sp);
      end

      // R4: LIFO burst with varied data
      lfsr = 8'hA1;
      for (int i = 0; i < 20; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         do_push(lfsr);
      end
      for (int i = 0; i < 20; i++) do_pop();
      // interleaved pattern
      do_push(8'h01); do_push(8'h02); do_pop(); do_push(8'h03); do_pop(); do_pop();

      // R5: relocate stack above bank area
      do_load(8'h30, 0);
      do_push(8'h77); do_push(8'h88); do_pop(); do_pop();

      // R6: load wins over push; byte at 0x42 must survive
      do_load(8'h41, 0); do_push(8'h55);
      do_load(8'h40, 0); do_push(8'h11);
      do_load(8'h41, 1);
      do_load(8'h42, 0); do_pop();
      do_pop();
      // R6: load wins over pop, no valid pulse follows
      do_load(8'h42, 2);
      @(negedge clk); #1;
      chk(!pop_vld_o, "R6 pop dropped", pop_vld_o, 0);

      // R7: wrap up and down
      do_load(8'hFF, 0);
      do_push(8'hA5);
      chk(sp_o == 8'h00, "R7 wrap to 0x00", sp_o, 8'h00);
      do_pop();
      chk(sp_o == 8'hFF, "R7 wrap to 0xFF", sp_o, 8'hFF);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all pops returned", exp_q.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule